// File: doc/BRIEF.md
# I/O Port Strobe Decoder

This block sits on the I/O side of an 8-bit CPU bus. It looks at the low address byte and the bus-cycle qualifiers, and it turns each qualifying I/O cycle into exactly one of eight active-low peripheral strobes. The peripherals it serves are an LED column latch, a pair of scan-sink latches, a DAC, two trigger latches, a miscellaneous output latch, a sample-and-hold multiplexer latch and a four-register interval timer. The timer also receives the two lowest address bits so that it can pick one of its internal registers.

Only address bits 2 to 4 select the strobe, and address bit 7 enables the decode. Bits 0, 1, 5 and 6 are ignored, so every strobe answers on several aliased port numbers. Opcode-fetch cycles never produce a strobe. The strobes and the timer sub-address come from a single output register stage, so they change one clock after the bus inputs are sampled. A parameter can remove this register.

Top module: `iodec_strobe`

## Requirements
- R1: When a cycle qualifies, the strobe index is address bit 4 (most significant), bit 3 and bit 2 (least significant), and sel_n[index] goes low. Index 0..7 serves the LED latch, scan sink, DAC, trigger B, trigger A, misc latch, sample/hold mux and timer, at canonical ports 0xE0, 0xE4, 0xE8, 0xEC, 0xF0, 0xF4, 0xF8 and 0xFC.
- R2: When address bit 7 is 0, all strobes stay high.
- R3: When m1_n is low (opcode fetch), all strobes stay high, whatever the other inputs are.
- R4: When iorq_n is high, all strobes stay high. At no time is more than one bit of sel_n low.
- R5: While rst_n is low, and on the first cycle after it is released, sel_n is 8'hFF and timer_a is 2'b00.
- R6: Address bits 0, 1, 5 and 6 have no effect on sel_n. For example, 0x80, 0xA3 and 0xE0 all assert index 0.
- R7: timer_a carries address bits 1:0 at all times, with the same latency as sel_n. Over the timer window 0xFC to 0xFF, these values 0, 1, 2 and 3 pick counter 0, counter 1, counter 2 and the control register.
- R8: Indices 0 to 6 assert only when wr_n is low. Index 7, the timer, asserts on both reads and writes. This follows the default write-only mask 8'h7F.
- R9: With the default OUT_REG=1, the inputs sampled at a rising clock edge show on sel_n and timer_a right after that edge. The outputs then hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Low byte of the CPU address bus |
| m1_n | input | 1 | Active-low opcode-fetch qualifier |
| iorq_n | input | 1 | Active-low I/O request qualifier |
| wr_n | input | 1 | Active-low write qualifier |
| sel_n | output | 8 | Active-low peripheral strobes, indices 0 to 7 |
| timer_a | output | 2 | Register select passed to the interval timer |

## Verification
On every clock, the assertions check several things. At most one strobe is low. An opcode fetch, an idle bus or a clear enable bit leaves all strobes high. A qualified cycle drives low the strobe named by the three select bits. The timer sub-address follows the previous cycle's low address bits. Only the bench's scenarios can show the complete mapping from address to peripheral across all 256 addresses, the effect of each aliased bit, the read/write mask of each index and the reset values. The bench shows these by comparing every cycle against a reference computed from arithmetic on the address value.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

   // Peripheral order on the strobe bus; the index is the select field value.
   typedef enum logic [2:0] {
      PER_LED_COL   = 3'd0,
      PER_SCAN_SINK = 3'd1,
      PER_DAC       = 3'd2,
      PER_TRIG_B    = 3'd3,
      PER_TRIG_A    = 3'd4,
      PER_MISC      = 3'd5,
      PER_SH_MUX    = 3'd6,
      PER_TIMER     = 3'd7
   } periph_e;

   localparam int unsigned DEF_ADDR_W  = 8;
   localparam int unsigned DEF_SEL_LSB = 2;
   localparam int unsigned DEF_SEL_W   = 3;
   localparam int unsigned DEF_EN_BIT  = 7;
   localparam int unsigned DEF_SUB_W   = 2;

   // Nonzero when the field [lsb +: w] fits inside a bus of width bus_w.
   function automatic bit field_fits(int unsigned lsb, int unsigned w, int unsigned bus_w);
      return (w > 0) && ((lsb + w) <= bus_w);
   endfunction

endpackage

// File: rtl/iodec_qualify.sv
module iodec_qualify
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned EN_BIT   = DEF_EN_BIT,
   parameter bit          EN_LEVEL = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              m1_n,
   input  logic              iorq_n,
   output logic              cycle_ok
);

   logic fetch_act;
   logic fetch_block_n;
   logic en_hit;
   logic io_act;
   logic unused_addr;

   // M1 is inverted and then used as an active-low enable:
   // a fetch (m1_n = 0) drives fetch_block_n low and kills the decode.
   assign fetch_act     = ~m1_n;
   assign fetch_block_n = ~fetch_act;
   assign en_hit        = (addr[EN_BIT] == EN_LEVEL);
   assign io_act        = ~iorq_n;
   assign cycle_ok      = io_act & fetch_block_n & en_hit;

   assign unused_addr   = ^addr;

endmodule

// File: rtl/iodec_onehot.sv
module iodec_onehot
   import iodec_pkg::*;
#(
   parameter int unsigned SEL_W        = DEF_SEL_W,
   parameter logic [(1<<SEL_W)-1:0] WR_ONLY_MASK = '1
) (
   input  logic [SEL_W-1:0]      idx,
   input  logic                  en,
   input  logic                  wr_n,
   output logic [(1<<SEL_W)-1:0] sel_n_d
);

   localparam int unsigned NUM_SEL = 1 << SEL_W;

   genvar g;
   generate
      for (g = 0; g < NUM_SEL; g++) begin : g_out
         logic hit;
         assign hit = en && (idx == SEL_W'(g));
         if (WR_ONLY_MASK[g]) begin : g_wr_only
            assign sel_n_d[g] = ~(hit & ~wr_n);
         end else begin : g_rd_wr
            assign sel_n_d[g] = ~hit;
         end
      end
   endgenerate

endmodule

// File: rtl/iodec_stage.sv
module iodec_stage #(
   parameter int unsigned W       = 10,
   parameter bit          OUT_REG = 1'b1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d;
         end
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/iodec_strobe.sv
module iodec_strobe
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned SEL_LSB  = DEF_SEL_LSB,
   parameter int unsigned SEL_W    = DEF_SEL_W,
   parameter int unsigned EN_BIT   = DEF_EN_BIT,
   parameter bit          EN_LEVEL = 1'b1,
   parameter int unsigned SUB_W    = DEF_SUB_W,
   parameter logic [(1<<SEL_W)-1:0] WR_ONLY_MASK = 8'h7F,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  m1_n,
   input  logic                  iorq_n,
   input  logic                  wr_n,
   output logic [(1<<SEL_W)-1:0] sel_n,
   output logic [SUB_W-1:0]      timer_a
);

   localparam int unsigned NUM_SEL = 1 << SEL_W;
   localparam int unsigned OUT_W   = NUM_SEL + SUB_W;
   localparam logic [OUT_W-1:0] OUT_RST = {{SUB_W{1'b0}}, {NUM_SEL{1'b1}}};

   // Elaboration-time parameter checks
   generate
      if (!field_fits(SEL_LSB, SEL_W, ADDR_W)) begin : g_bad_sel
         $error("select field does not fit the address bus");
      end
      if (EN_BIT >= ADDR_W) begin : g_bad_en
         $error("enable bit outside the address bus");
      end
      if ((EN_BIT >= SEL_LSB) && (EN_BIT < SEL_LSB + SEL_W)) begin : g_en_overlap
         $error("enable bit overlaps the select field");
      end
      if (SUB_W > SEL_LSB) begin : g_bad_sub
         $error("timer sub-address overlaps the select field");
      end
   endgenerate

   logic                 cycle_ok;
   logic [SEL_W-1:0]     sel_idx;
   logic [NUM_SEL-1:0]   sel_n_d;
   logic [OUT_W-1:0]     stage_d;
   logic [OUT_W-1:0]     stage_q;

   iodec_qualify #(
      .ADDR_W   (ADDR_W),
      .EN_BIT   (EN_BIT),
      .EN_LEVEL (EN_LEVEL)
   ) qual_i (
      .addr     (addr),
      .m1_n     (m1_n),
      .iorq_n   (iorq_n),
      .cycle_ok (cycle_ok)
   );

   assign sel_idx = addr[SEL_LSB +: SEL_W];

   iodec_onehot #(
      .SEL_W        (SEL_W),
      .WR_ONLY_MASK (WR_ONLY_MASK)
   ) dec_i (
      .idx     (sel_idx),
      .en      (cycle_ok),
      .wr_n    (wr_n),
      .sel_n_d (sel_n_d)
   );

   assign stage_d = {addr[SUB_W-1:0], sel_n_d};

   iodec_stage #(
      .W       (OUT_W),
      .OUT_REG (OUT_REG),
      .RST_VAL (OUT_RST)
   ) stage_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (stage_d),
      .q     (stage_q)
   );

   assign sel_n   = stage_q[NUM_SEL-1:0];
   assign timer_a = stage_q[OUT_W-1:NUM_SEL];

   // Assertions on the registered variant, checked against the bus inputs
   generate
      if (OUT_REG) begin : g_chk
         p_one_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(~sel_n) <= 1)
            else $error("more than one strobe low");

         p_no_io_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(iorq_n)) |-> (&sel_n))
            else $error("strobe without I/O request");

         p_fetch_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(m1_n)) |-> (&sel_n))
            else $error("strobe during opcode fetch");

         p_enable_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(addr[EN_BIT]) != EN_LEVEL)) |-> (&sel_n))
            else $error("strobe with enable bit clear");

         p_index_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(iorq_n) && $past(m1_n) && !$past(wr_n)
             && ($past(addr[EN_BIT]) == EN_LEVEL))
            |-> !sel_n[$past(addr[SEL_LSB +: SEL_W])])
            else $error("addressed strobe not asserted");

         p_timer_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (timer_a == $past(addr[SUB_W-1:0])))
            else $error("timer sub-address mismatch");
      end
   endgenerate

endmodule

// File: tb/iodec_strobe_tb.sv
module iodec_strobe_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = 8'h00;
   logic       m1_n = 1'b1;
   logic       iorq_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] sel_n;
   logic [1:0] timer_a;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   iodec_strobe dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .m1_n    (m1_n),
      .iorq_n  (iorq_n),
      .wr_n    (wr_n),
      .sel_n   (sel_n),
      .timer_a (timer_a)
   );

   // Behavioural reference: arithmetic on the address value.
   function automatic logic [7:0] ref_sel(int a, bit m1, bit iorq, bit wr);
      int idx;
      bit need_wr;
      logic [7:0] r;
      r = 8'hFF;
      idx = (a / 4) % 8;
      need_wr = (idx != 7);          // R8: only the timer accepts reads
      if (iorq == 1'b0 && m1 == 1'b1 && a >= 128 && (!need_wr || wr == 1'b0))
         r[idx] = 1'b0;
      return r;
   endfunction

   task automatic check(string tag, logic [7:0] exp_sel, logic [1:0] exp_ta);
      n_cmp++;
      if (sel_n !== exp_sel || timer_a !== exp_ta) begin
         n_bad++;
         $display("FAIL %s addr=%02h m1_n=%b iorq_n=%b wr_n=%b: sel_n=%02h timer_a=%0d expected sel_n=%02h timer_a=%0d",
                  tag, addr, m1_n, iorq_n, wr_n, sel_n, timer_a, exp_sel, exp_ta);
      end
   endtask

   // Drive at negedge, let the edge register it, sample 1 ns later (R9).
   task automatic cyc(string tag, int a, bit m1, bit iorq, bit wr);
      @(negedge clk);
      addr = 8'(a); m1_n = m1; iorq_n = iorq; wr_n = wr;
      @(posedge clk);
      #1;
      check(tag, ref_sel(a, m1, iorq, wr), 2'(a % 4));
   endtask

   task automatic expect_port(string tag, int a, bit wr, int idx);
      logic [7:0] e;
      e = 8'hFF;
      e[idx] = 1'b0;
      @(negedge clk);
      addr = 8'(a); m1_n = 1'b1; iorq_n = 1'b0; wr_n = wr;
      @(posedge clk);
      #1;
      check(tag, e, 2'(a % 4));
   endtask

   initial begin
      // R5: reset state
      addr = 8'hF0; m1_n = 1'b1; iorq_n = 1'b0; wr_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R5 in reset", 8'hFF, 2'b00);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 check("R9 first edge after reset", ref_sel(8'hF0, 1, 0, 0), 2'b00);

      // R1: canonical ports, independent expectation per peripheral
      for (int i = 0; i < 8; i++)
         expect_port("R1 canonical port", 224 + 4 * i, 1'b0, i);

      // R6: aliases of each port through bits 0,1,5,6
      expect_port("R6 alias 0x80", 8'h80, 1'b0, 0);
      expect_port("R6 alias 0xA3", 8'hA3, 1'b0, 0);
      expect_port("R6 alias 0xC5", 8'hC5, 1'b0, 1);
      expect_port("R6 alias 0x9E", 8'h9E, 1'b0, 7);

      // R7: timer window sub-addresses, write and read
      for (int s = 0; s < 4; s++) expect_port("R7 timer write", 252 + s, 1'b0, 7);
      for (int s = 0; s < 4; s++) expect_port("R7 timer read", 252 + s, 1'b1, 7);

      // R8: reads to write-only ports give nothing
      for (int i = 0; i < 7; i++) cyc("R8 read of write-only port", 224 + 4 * i, 1'b1, 1'b0, 1'b1);

      // Full sweeps: every address, M1 both ways, write and read
      for (int a = 0; a < 256; a++) cyc("R2 R1 sweep write", a, 1'b1, 1'b0, 1'b0);
      for (int a = 0; a < 256; a++) cyc("R8 sweep read", a, 1'b1, 1'b0, 1'b1);
      for (int a = 0; a < 256; a++) cyc("R3 sweep opcode fetch", a, 1'b0, 1'b0, 1'b0);
      for (int a = 0; a < 256; a += 3) cyc("R4 sweep idle bus", a, 1'b1, 1'b1, 1'b0);

      // R9: outputs hold between edges
      cyc("R9 setup", 8'hE8, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      addr = 8'h00; iorq_n = 1'b1;
      #1 check("R9 hold until next edge", 8'hFB, 2'b00);
      @(posedge clk);
      #1 check("R9 update at edge", 8'hFF, 2'b00);

      // R5: reset during an active cycle
      cyc("R5 before reset", 8'hF7, 1'b1, 1'b0, 1'b0);
      @(negedge clk) rst_n = 1'b0;
      #1 check("R5 asynchronous reset", 8'hFF, 2'b00);
      @(negedge clk) rst_n = 1'b1;
      cyc("R5 after reset", 8'hF7, 1'b1, 1'b0, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule